// File: doc/BRIEF.md
# Parallel flash write-cycle qualifier

This block sits between an asynchronous parallel-flash-style control bus and the command state machine inside the device. The bus has active-low chip enable, write enable and output enable strobes, plus address and data. The block samples these pins with the system clock and rejects pulses that are too short. It decides when a complete and legal write cycle has taken place. Each accepted write is handed to the command logic as a single-cycle strobe, with the address and data that were on the bus when the cycle ended.

The block also provides the write protection that depends on supply and power-up state. A digital supply-OK input reports whether the supply is above the lockout threshold. While it is low, no write is passed on and the command logic is held in its read-array reset. After a reset, or after the supply comes back, a write whose strobes were already asserted is refused. It stays refused until chip enable or write enable has been seen inactive. Decoding the unlock sequences and the array itself belong to the command logic, which receives every accepted write in bus order.

Top module: `flash_wr_qualifier`

## Requirements
- R1: While reset is asserted, and until the synchronised supply-OK input reads high, `cmd_rd_reset` is 1 and `cmd_stb` is 0. `cmd_rd_reset` falls two clock edges after reset release when `supply_ok` is already high.
- R2: A write cycle starts only when the filtered chip enable and write enable are both 0 and output enable is 1. It is accepted when chip enable or write enable returns to 1, whichever comes first.
- R3: Output enable at 0, chip enable at 1, or write enable at 1 each prevents a write cycle from starting. Output enable falling to 0 during a started cycle cancels it, so no strobe is issued for that cycle.
- R4: A level change on any control pin is accepted only after the synchronised pin has held the new level for N_GLITCH consecutive clock samples. A write-enable low pulse shorter than N_GLITCH cycles starts no cycle. A write-enable high pulse shorter than N_GLITCH cycles does not end a started cycle.
- R5: `cmd_stb` is high for exactly one cycle per accepted write. It becomes visible N_GLITCH+3 clock edges after the pin edge that ends the cycle.
- R6: `cmd_addr` and `cmd_data` take the bus address and data, after their two-stage synchroniser, in the cycle the end of the write is recognised. They then hold their value until the next strobe. The bus must keep address and data stable from the start of the cycle until N_GLITCH+4 cycles after its end.
- R7: While the synchronised `supply_ok` is 0, `cmd_rd_reset` is 1 and no strobe is issued. A cycle already in progress when the supply drops is discarded.
- R8: After reset, and after every supply recovery, no write is accepted until filtered chip enable or write enable has been seen at 1. A cycle whose strobes were held asserted through reset or through the outage is therefore refused.
- R9: Every accepted write produces one strobe, and strobes appear in the order of the writes on the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_ce_n | input | 1 | Chip enable from the bus, active low, asynchronous |
| bus_we_n | input | 1 | Write enable from the bus, active low, asynchronous |
| bus_oe_n | input | 1 | Output enable from the bus, active low, asynchronous |
| bus_addr | input | ADDR_W | Bus address |
| bus_data | input | DATA_W | Bus write data |
| supply_ok | input | 1 | High when the supply is above the write lockout threshold |
| cmd_stb | output | 1 | One-cycle strobe per accepted write |
| cmd_addr | output | ADDR_W | Address of the last accepted write |
| cmd_data | output | DATA_W | Data of the last accepted write |
| cmd_rd_reset | output | 1 | Holds the command logic in read-array reset |

## Verification
The hardest situations to reach from the ports are the ones where the strobes are already asserted when the block becomes able to accept writes. The bench holds chip enable and write enable low with output enable high across reset release. Later it holds them low across a supply outage and recovery. It then releases write enable and checks that no strobe follows, while a fresh cycle afterwards is accepted. Glitch rejection is swept over every pulse width from one cycle up past N_GLITCH, in both polarities. The strobe position is checked against the exact N_GLITCH+3 edge latency.

// File: rtl/fwq_pkg.sv
package fwq_pkg;
  typedef enum logic [1:0] {
    ST_LOCKED = 2'd0,
    ST_ARMED  = 2'd1,
    ST_ACTIVE = 2'd2
  } fwq_state_e;

  localparam int unsigned PIN_OE = 0;
  localparam int unsigned PIN_WE = 1;
  localparam int unsigned PIN_CE = 2;
  localparam int unsigned N_PINS = 3;
endpackage

// File: rtl/fwq_sync.sv
module fwq_sync #(
  parameter int unsigned W       = 1,
  parameter logic        RST_BIT = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= {W{RST_BIT}};
      q    <= {W{RST_BIT}};
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/fwq_glitch.sv
module fwq_glitch #(
  parameter int unsigned N_GLITCH = 3,
  parameter logic        RST_BIT  = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_s,
  output logic pin_f
);
  localparam int unsigned CW = (N_GLITCH < 2) ? 1 : $clog2(N_GLITCH);
  localparam logic [CW-1:0] LAST = CW'(N_GLITCH - 1);

  logic [CW-1:0] cnt, cnt_nxt;
  logic          f_nxt;

  always_comb begin
    f_nxt   = pin_f;
    cnt_nxt = '0;
    if (pin_s != pin_f) begin
      if (cnt == LAST) begin
        f_nxt   = pin_s;
        cnt_nxt = '0;
      end else begin
        cnt_nxt = cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      pin_f <= RST_BIT;
    end else begin
      cnt   <= cnt_nxt;
      pin_f <= f_nxt;
    end
  end
endmodule

// File: rtl/fwq_fsm.sv
module fwq_fsm
  import fwq_pkg::*;
#(
  parameter int unsigned ADDR_W = 11,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_f,
  input  logic              we_f,
  input  logic              oe_f,
  input  logic              sup_ok,
  input  logic [ADDR_W-1:0] addr_s,
  input  logic [DATA_W-1:0] data_s,
  output logic              stb,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] data_q,
  output fwq_state_e        state
);
  fwq_state_e st_nxt;
  logic       stb_nxt;
  logic       cap_en;
  logic       start_ok;
  logic       released;

  // filtered pins: both strobes asserted with output enable inactive
  assign start_ok = !ce_f && !we_f && oe_f;
  assign released = ce_f || we_f;

  always_comb begin
    st_nxt  = state;
    stb_nxt = 1'b0;
    cap_en  = 1'b0;
    case (state)
      ST_LOCKED: begin
        if (sup_ok && released) st_nxt = ST_ARMED;
      end
      ST_ARMED: begin
        if (!sup_ok)        st_nxt = ST_LOCKED;
        else if (start_ok)  st_nxt = ST_ACTIVE;
      end
      ST_ACTIVE: begin
        if (!sup_ok || !oe_f) begin
          st_nxt = ST_LOCKED;
        end else if (released) begin
          st_nxt  = ST_ARMED;
          stb_nxt = 1'b1;
          cap_en  = 1'b1;
        end
      end
      default: st_nxt = ST_LOCKED;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_LOCKED;
      stb   <= 1'b0;
    end else begin
      state <= st_nxt;
      stb   <= stb_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
    end else if (cap_en) begin
      addr_q <= addr_s;
      data_q <= data_s;
    end
  end
endmodule

// File: rtl/flash_wr_qualifier.sv
module flash_wr_qualifier
  import fwq_pkg::*;
#(
  parameter int unsigned ADDR_W   = 11,
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned N_GLITCH = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_ce_n,
  input  logic              bus_we_n,
  input  logic              bus_oe_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_data,
  input  logic              supply_ok,
  output logic              cmd_stb,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [DATA_W-1:0] cmd_data,
  output logic              cmd_rd_reset
);
  localparam int unsigned BUS_W = ADDR_W + DATA_W;

  logic [N_PINS-1:0] ctl_raw, ctl_s, ctl_f;
  logic [BUS_W-1:0]  bus_s;
  logic              sup_s;
  fwq_state_e        state;
  logic              in_active;
  logic              we_sync, we_filt;

  assign ctl_raw[PIN_CE] = bus_ce_n;
  assign ctl_raw[PIN_WE] = bus_we_n;
  assign ctl_raw[PIN_OE] = bus_oe_n;

  // control pins reset to the asserted level so pins held low stay locked
  fwq_sync #(.W(N_PINS), .RST_BIT(1'b0)) u_ctl_sync (
    .clk(clk), .rst_n(rst_n), .d(ctl_raw), .q(ctl_s)
  );

  fwq_sync #(.W(BUS_W), .RST_BIT(1'b0)) u_bus_sync (
    .clk(clk), .rst_n(rst_n), .d({bus_addr, bus_data}), .q(bus_s)
  );

  fwq_sync #(.W(1), .RST_BIT(1'b0)) u_sup_sync (
    .clk(clk), .rst_n(rst_n), .d(supply_ok), .q(sup_s)
  );

  for (genvar gi = 0; gi < N_PINS; gi++) begin : g_filt
    fwq_glitch #(.N_GLITCH(N_GLITCH), .RST_BIT(1'b0)) u_glitch (
      .clk(clk), .rst_n(rst_n), .pin_s(ctl_s[gi]), .pin_f(ctl_f[gi])
    );
  end

  fwq_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
    .clk    (clk),
    .rst_n  (rst_n),
    .ce_f   (ctl_f[PIN_CE]),
    .we_f   (ctl_f[PIN_WE]),
    .oe_f   (ctl_f[PIN_OE]),
    .sup_ok (sup_s),
    .addr_s (bus_s[BUS_W-1:DATA_W]),
    .data_s (bus_s[DATA_W-1:0]),
    .stb    (cmd_stb),
    .addr_q (cmd_addr),
    .data_q (cmd_data),
    .state  (state)
  );

  assign cmd_rd_reset = !sup_s;
  assign in_active    = (state == ST_ACTIVE);
  assign we_sync      = ctl_s[PIN_WE];
  assign we_filt      = ctl_f[PIN_WE];
endmodule

// File: rtl/fwq_checker.sv
module fwq_checker #(
  parameter int unsigned ADDR_W = 11,
  parameter int unsigned DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_stb,
  input logic              cmd_rd_reset,
  input logic [ADDR_W-1:0] cmd_addr,
  input logic [DATA_W-1:0] cmd_data,
  input logic              in_active,
  input logic              we_sync,
  input logic              we_filt
);
  // R5: strobe lasts one cycle
  assert_stb_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_stb |=> !cmd_stb);

  // R7: no strobe follows a cycle with the supply lockout active
  assert_no_stb_lockout_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_rd_reset |=> !cmd_stb);

  // R6: captured address and data change only with a strobe
  assert_hold_outputs_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_stb |-> ($stable(cmd_addr) && $stable(cmd_data)));

  // R2: a strobe only ends a started write cycle
  assert_stb_from_active_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_stb |-> $past(in_active));

  // R4: the filtered pin only ever takes the synchronised level
  assert_filter_follows_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(we_filt) |-> ($past(we_sync) == we_filt));
endmodule

bind flash_wr_qualifier fwq_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cmd_stb      (cmd_stb),
  .cmd_rd_reset (cmd_rd_reset),
  .cmd_addr     (cmd_addr),
  .cmd_data     (cmd_data),
  .in_active    (in_active),
  .we_sync      (we_sync),
  .we_filt      (we_filt)
);

// File: tb/sim_flash_wr_qualifier.sv
`timescale 1ns/1ps
module sim_flash_wr_qualifier;
  localparam int AW = 11;
  localparam int DW = 16;
  localparam int NG = 3;
  localparam int SETTLE = NG + 6;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          ce_n, we_n, oe_n, sup;
  logic [AW-1:0] addr;
  logic [DW-1:0] data;
  logic          cmd_stb, cmd_rd_reset;
  logic [AW-1:0] cmd_addr;
  logic [DW-1:0] cmd_data;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  int n_stb = 0;
  int stb_cyc = 0;
  int log_a [64];
  int log_d [64];
  bit done = 1'b0;

  always #4 clk = ~clk;

  flash_wr_qualifier #(.ADDR_W(AW), .DATA_W(DW), .N_GLITCH(NG)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_ce_n(ce_n), .bus_we_n(we_n), .bus_oe_n(oe_n),
    .bus_addr(addr), .bus_data(data), .supply_ok(sup),
    .cmd_stb(cmd_stb), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
    .cmd_rd_reset(cmd_rd_reset)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (cmd_stb) begin
      log_a[n_stb % 64] = int'(cmd_addr);
      log_d[n_stb % 64] = int'(cmd_data);
      stb_cyc = cyc;
      n_stb++;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // full write; end_ce selects chip enable as the ending edge
  task automatic do_write(input int a, input int d, input bit end_ce, input string req);
    int base, c0;
    base = n_stb;
    addr = AW'(a); data = DW'(d);
    ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1;
    tick(SETTLE);
    c0 = cyc;
    if (end_ce) ce_n = 1'b1; else we_n = 1'b1;
    tick(SETTLE);
    ce_n = 1'b1; we_n = 1'b1;
    tick(SETTLE);
    check(n_stb == base + 1, {req, " one strobe"}, n_stb - base, 1);
    check(stb_cyc - c0 == NG + 3, "R5 latency", stb_cyc - c0, NG + 3);
    check(log_a[base % 64] == a, "R6 addr", log_a[base % 64], a);
    check(log_d[base % 64] == d, "R6 data", log_d[base % 64], d);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int base;
    // R8: strobes held asserted through reset
    rst_n = 1'b0; sup = 1'b1; ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1;
    addr = '0; data = '0;
    tick(3);
    check(cmd_rd_reset == 1'b1, "R1 reset state rd_reset", cmd_rd_reset, 1);
    check(cmd_stb == 1'b0, "R1 reset state stb", cmd_stb, 0);
    rst_n = 1'b1;
    tick(1);
    check(cmd_rd_reset == 1'b1, "R1 rd_reset after 1 edge", cmd_rd_reset, 1);
    tick(1);
    check(cmd_rd_reset == 1'b0, "R1 rd_reset after 2 edges", cmd_rd_reset, 0);
    tick(SETTLE * 2);
    we_n = 1'b1;
    tick(SETTLE);
    ce_n = 1'b1;
    tick(SETTLE);
    check(n_stb == 0, "R8 power-up inhibit", n_stb, 0);

    // R2 / R9: ordered writes, both ending edges
    do_write(11'h555, 16'h00AA, 1'b0, "R2 we-ended");
    do_write(11'h2AA, 16'h0055, 1'b1, "R2 ce-ended");
    do_write(11'h555, 16'h00A0, 1'b0, "R9 third");
    check(log_a[0] == 32'h555 && log_a[1] == 32'h2AA && log_a[2] == 32'h555,
          "R9 order", log_a[1], 32'h2AA);

    // R4: low pulses on write enable of every width
    for (int w = 1; w <= NG + 2; w++) begin
      base = n_stb;
      addr = AW'(w); data = DW'(16'h1000 + w);
      ce_n = 1'b0; oe_n = 1'b1; we_n = 1'b1;
      tick(SETTLE);
      we_n = 1'b0;
      tick(w);
      we_n = 1'b1;
      tick(SETTLE);
      check(n_stb - base == ((w >= NG) ? 1 : 0), "R4 low pulse", n_stb - base,
            (w >= NG) ? 1 : 0);
    end
    ce_n = 1'b1;
    tick(SETTLE);

    // R4: short high pulses do not end a started cycle
    for (int w = 1; w < NG; w++) begin
      base = n_stb;
      ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1;
      tick(SETTLE);
      we_n = 1'b1;
      tick(w);
      we_n = 1'b0;
      tick(SETTLE);
      check(n_stb == base, "R4 high glitch", n_stb - base, 0);
      we_n = 1'b1;
      tick(SETTLE);
      check(n_stb == base + 1, "R4 end after glitch", n_stb - base, 1);
      ce_n = 1'b1;
      tick(SETTLE);
    end

    // R3: blocking conditions
    base = n_stb;
    ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b0;
    tick(SETTLE);
    we_n = 1'b1;
    tick(SETTLE);
    check(n_stb == base, "R3 oe low blocks", n_stb - base, 0);
    oe_n = 1'b1; ce_n = 1'b1;
    tick(SETTLE);
    we_n = 1'b0;
    tick(SETTLE);
    we_n = 1'b1;
    tick(SETTLE);
    check(n_stb == base, "R3 ce high blocks", n_stb - base, 0);
    ce_n = 1'b0; we_n = 1'b0;
    tick(SETTLE);
    oe_n = 1'b0;
    tick(SETTLE);
    oe_n = 1'b1;
    tick(SETTLE);
    we_n = 1'b1;
    tick(SETTLE);
    check(n_stb == base, "R3 oe abort", n_stb - base, 0);
    ce_n = 1'b1;
    tick(SETTLE);
    do_write(11'h0F0, 16'hBEEF, 1'b0, "R3 after abort");

    // R7: supply lockout
    base = n_stb;
    sup = 1'b0;
    tick(3);
    check(cmd_rd_reset == 1'b1, "R7 rd_reset in lockout", cmd_rd_reset, 1);
    addr = 11'h123; data = 16'h4321;
    ce_n = 1'b0; we_n = 1'b0;
    tick(SETTLE);
    we_n = 1'b1;
    tick(SETTLE);
    check(n_stb == base, "R7 write ignored", n_stb - base, 0);
    check(cmd_addr == 11'h0F0, "R7 addr untouched", int'(cmd_addr), 32'h0F0);
    ce_n = 1'b1;
    sup = 1'b1;
    tick(SETTLE);
    ce_n = 1'b0; we_n = 1'b0;
    tick(SETTLE);
    sup = 1'b0;
    tick(SETTLE);
    we_n = 1'b1;
    tick(SETTLE);
    check(n_stb == base, "R7 in-flight cycle dropped", n_stb - base, 0);

    // R8: recovery with strobes held asserted
    we_n = 1'b0;
    tick(SETTLE);
    sup = 1'b1;
    tick(SETTLE);
    check(cmd_rd_reset == 1'b0, "R8 rd_reset released", cmd_rd_reset, 0);
    we_n = 1'b1;
    tick(SETTLE);
    check(n_stb == base, "R8 recovery inhibit", n_stb - base, 0);
    ce_n = 1'b1;
    tick(SETTLE);
    do_write(11'h7FF, 16'hFFFF, 1'b1, "R8 after recovery");

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule